// File: doc/BRIEF.md
# Fractional Output Bit Advancer

This block sends a serial time-division multiplexed stream built from channel bytes that it fetches one at a time over a simple parallel request interface. It runs on an oversampling clock of 16 ticks per frame-clock cycle. It can launch every output transition earlier than the nominal bit edge by a small programmable fraction of a bit, so that the stream arrives at a distant receiver aligned with the clock seen there.

Two rates are supported. At the low rate a bit lasts 16 ticks and a frame carries `LO_CHANNELS` channels. At the high rate a bit lasts 8 ticks and a frame carries twice as many channels. A frame pulse marks the frame boundary, and the block counts ticks freely between pulses. A 2-bit advance code selects an offset of 0 to 3 steps. A step is a quarter bit at the low rate and an eighth of a bit at the high rate. When the offset is not zero, the first bit of channel 0 starts inside the last bit period of the previous frame. The byte for each channel is requested a few ticks before it is needed. The rate and the advance code are sampled only at a frame boundary.

Top module: `frac_adv_tx`

## Requirements
- R1: After reset, and until the first `framePulse` after it, `serOut` and `byteReq` stay low.
- R2: `framePulse` is high for the last tick of a frame. The next tick is nominal position 0, where bit 7 of channel 0 begins when the advance code is 0.
- R3: At the low rate (`rateHi`=0), every bit lasts 16 ticks, the bits of a channel go out bit 7 first, and the channels run from 0 to `LO_CHANNELS`-1 in increasing order.
- R4: At the high rate (`rateHi`=1), every bit lasts 8 ticks, and the channels run from 0 to 2×`LO_CHANNELS`-1.
- R5: At the low rate, every output transition occurs 4×`advSel` ticks before its nominal position.
- R6: At the high rate, every output transition occurs `advSel` ticks before its nominal position.
- R7: With a non-zero offset, bit 7 of channel 0 is already driven during the final offset ticks of the previous frame.
- R8: `byteReq` is high for exactly one tick, and in that tick `reqChan` names the next channel. `byteIn` is sampled at the end of the following tick. The requested byte starts on `serOut` 4 ticks after the request tick.
- R9: The request made during the last channel of a frame names channel 0.
- R10: `rateHi` and `advSel` are sampled only at the end of the advanced frame, so a change in mid-frame leaves the rest of that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 ticks per frame-clock cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| framePulse | input | 1 | High during the last tick of each frame |
| rateHi | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| advSel | input | 2 | Advance code, 0 to 3 steps |
| byteIn | input | 8 | Byte for the channel requested in the previous tick |
| byteReq | output | 1 | One-tick byte request strobe |
| reqChan | output | $clog2(LO_CHANNELS)+1 | Channel number of the request |
| serOut | output | 1 | Serial output stream |

## Verification
The bench builds the block with `LO_CHANNELS` set to 8. This makes a frame 1024 ticks long, so the bench sees many frames within its run. It therefore reaches the channel-count wrap, the launches of channel 0 in the tail of the previous frame, and many boundary changes of the configuration. The rate is a port, so this one build covers both rates and all four advance codes. Each configuration is set in the middle of the frame before the one it is checked in, which also covers the mid-frame sampling rule.

// File: rtl/frac_adv_pkg.sv
package frac_adv_pkg;

  localparam int CHAN_BITS    = 8;
  localparam int LO_BIT_TICKS = 16;
  localparam int HI_BIT_TICKS = 8;
  localparam int LO_STEP      = LO_BIT_TICKS / 4;
  localparam int HI_STEP      = HI_BIT_TICKS / 8;

  typedef struct packed {
    logic request;
    logic capture;
    logic load;
    logic shift;
  } strobe_t;

  typedef struct packed {
    logic       hi;
    logic [1:0] code;
  } cfg_t;

endpackage

// File: rtl/frac_adv_ctl.sv
module frac_adv_ctl
  import frac_adv_pkg::*;
#(
  parameter int LO_CHANNELS = 128,
  localparam int CH_W = $clog2(LO_CHANNELS) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            framePulse,
  input  logic            rateHi,
  input  logic [1:0]      advSel,
  output strobe_t         stb,
  output logic            byteReq,
  output logic [CH_W-1:0] reqChan
);

  localparam int LO_CHAN_TICKS = CHAN_BITS * LO_BIT_TICKS;
  localparam int HI_CHAN_TICKS = CHAN_BITS * HI_BIT_TICKS;
  localparam int FRAME_TICKS   = LO_CHANNELS * LO_CHAN_TICKS;
  localparam int POS_W         = $clog2(FRAME_TICKS);
  localparam int PH_W          = $clog2(LO_CHAN_TICKS);
  localparam int HI_PH_W       = $clog2(HI_CHAN_TICKS);
  localparam int BP_W          = $clog2(LO_BIT_TICKS);
  localparam int HI_BP_W       = $clog2(HI_BIT_TICKS);

  logic [POS_W-1:0] nomPos;
  logic             locked;
  cfg_t             cfgQ;

  logic [POS_W-1:0] offTicks;
  logic [POS_W-1:0] curAdv;
  logic [PH_W-1:0]  chanPhase;
  logic [PH_W-1:0]  chanLast;
  logic [BP_W-1:0]  bitPhase;
  logic [BP_W-1:0]  bitLast;
  logic [CH_W-1:0]  chanIdx;
  logic [CH_W-1:0]  lastChan;
  logic             frameEnd;
  logic             latchEn;

  // advanced position = nominal position plus the launch offset
  always_comb begin
    offTicks = cfgQ.hi ? POS_W'(cfgQ.code * HI_STEP) : POS_W'(cfgQ.code * LO_STEP);
    curAdv   = nomPos + offTicks;
    if (cfgQ.hi) begin
      chanPhase = PH_W'(curAdv[HI_PH_W-1:0]);
      chanLast  = PH_W'(HI_CHAN_TICKS - 1);
      bitPhase  = BP_W'(curAdv[HI_BP_W-1:0]);
      bitLast   = BP_W'(HI_BIT_TICKS - 1);
      chanIdx   = curAdv[POS_W-1:HI_PH_W];
      lastChan  = CH_W'(2 * LO_CHANNELS - 1);
    end else begin
      chanPhase = curAdv[PH_W-1:0];
      chanLast  = PH_W'(LO_CHAN_TICKS - 1);
      bitPhase  = curAdv[BP_W-1:0];
      bitLast   = BP_W'(LO_BIT_TICKS - 1);
      chanIdx   = {1'b0, curAdv[POS_W-1:PH_W]};
      lastChan  = CH_W'(LO_CHANNELS - 1);
    end
    frameEnd = (curAdv == POS_W'(FRAME_TICKS - 1));
    latchEn  = (locked && frameEnd) || (framePulse && !locked);
  end

  // strobes to the datapath, only once aligned to a frame
  always_comb begin
    stb.load    = locked && (chanPhase == chanLast);
    stb.shift   = locked && (chanPhase != chanLast) && (bitPhase == bitLast);
    stb.capture = locked && (chanPhase == chanLast - PH_W'(2));
    stb.request = locked && (chanPhase == chanLast - PH_W'(3));
  end

  assign byteReq = stb.request;
  assign reqChan = (chanIdx == lastChan) ? '0 : chanIdx + CH_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nomPos <= '0;
      locked <= 1'b0;
      cfgQ   <= '0;
    end else begin
      if (framePulse) begin
        nomPos <= '0;
        locked <= 1'b1;
      end else begin
        nomPos <= nomPos + POS_W'(1);
      end
      if (latchEn) cfgQ <= '{hi: rateHi, code: advSel};
    end
  end

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteReq |=> !byteReq);

  assert_req_then_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteReq |=> stb.capture);

  assert_lock_by_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(framePulse));

  assert_cfg_at_boundary_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ != $past(cfgQ)) |-> $past(latchEn));

endmodule

// File: rtl/frac_adv_dp.sv
module frac_adv_dp
  import frac_adv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [CHAN_BITS-1:0] byteIn,
  output logic                 serOut
);

  logic [CHAN_BITS-1:0] nextByte;
  logic [CHAN_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextByte <= '0;
      shreg    <= '0;
    end else begin
      if (stb.capture) nextByte <= byteIn;
      if (stb.load)       shreg <= nextByte;
      else if (stb.shift) shreg <= {shreg[CHAN_BITS-2:0], 1'b0};
    end
  end

  assign serOut = shreg[CHAN_BITS-1];

  assert_hold_between_edges_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load || stb.shift) |=> $stable(serOut));

endmodule

// File: rtl/frac_adv_tx.sv
module frac_adv_tx
  import frac_adv_pkg::*;
#(
  parameter int LO_CHANNELS = 128,
  localparam int CH_W = $clog2(LO_CHANNELS) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            framePulse,
  input  logic            rateHi,
  input  logic [1:0]      advSel,
  input  logic [7:0]      byteIn,
  output logic            byteReq,
  output logic [CH_W-1:0] reqChan,
  output logic            serOut
);

  strobe_t stb;

  frac_adv_ctl #(.LO_CHANNELS(LO_CHANNELS)) ctl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .rateHi     (rateHi),
    .advSel     (advSel),
    .stb        (stb),
    .byteReq    (byteReq),
    .reqChan    (reqChan)
  );

  frac_adv_dp dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .byteIn (byteIn),
    .serOut (serOut)
  );

endmodule

// File: tb/frac_adv_tx_test.sv
module frac_adv_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int LO  = 8;
  localparam int CHW = $clog2(LO) + 1;
  localparam int F   = LO * 128;
  localparam int NV  = 10;

  typedef struct packed {
    logic       hi;
    logic [1:0] code;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0}, '{1'b0, 2'd1}, '{1'b0, 2'd3}, '{1'b0, 2'd3}, '{1'b1, 2'd0},
    '{1'b1, 2'd2}, '{1'b1, 2'd3}, '{1'b1, 2'd3}, '{1'b0, 2'd2}, '{1'b1, 2'd1}
  };

  logic           clk = 1'b0;
  logic           rstN;
  logic           framePulse;
  logic           rateHi;
  logic [1:0]     advSel;
  logic [7:0]     byteIn;
  logic           byteReq;
  logic [CHW-1:0] reqChan;
  logic           serOut;

  int total = 0;
  int bad   = 0;
  int pn;
  bit pulseEn;
  int lastChan = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frac_adv_tx #(.LO_CHANNELS(LO)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .rateHi     (rateHi),
    .advSel     (advSel),
    .byteIn     (byteIn),
    .byteReq    (byteReq),
    .reqChan    (reqChan),
    .serOut     (serOut)
  );

  function automatic logic [7:0] dat(input int ch);
    return 8'((ch * 29 + 7) ^ (ch << 3));
  endfunction

  assign byteIn = dat(lastChan);

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at pos %0d: actual=%0d expected=%0d", tag, what, pn, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    pn = (pn + 1) % F;
    framePulse = pulseEn && (pn == F - 1);
    @(negedge clk);
    if (byteReq) lastChan = int'(reqChan);
  endtask

  task automatic checkTick(input vec_t v, input bit changed);
    int ct, bt, o, nCh, a, ch, bi;
    logic [7:0] d;
    string tag;
    ct  = v.hi ? 64 : 128;
    bt  = v.hi ? 8 : 16;
    o   = v.hi ? int'(v.code) : 4 * int'(v.code);
    nCh = v.hi ? 2 * LO : LO;
    a   = (pn + o) % F;
    ch  = a / ct;
    bi  = 7 - (a % ct) / bt;
    d   = dat(ch);
    if (pn >= F - o)                 tag = "R7";
    else if (changed && pn >= F / 2) tag = "R10";
    else if (o == 0 && pn < bt)      tag = "R2";
    else if (o != 0)                 tag = v.hi ? "R6" : "R5";
    else                             tag = v.hi ? "R4" : "R3";
    check(tag, int'(serOut), int'(d[bi]), "serOut");
    check("R8", int'(byteReq), int'(a % ct == ct - 4), "byteReq");
    if (a % ct == ct - 4)
      check((ch == nCh - 1) ? "R9" : "R8", int'(reqChan), (ch + 1) % nCh, "reqChan");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN       = 1'b0;
    framePulse = 1'b0;
    pulseEn    = 1'b0;
    pn         = F - 40;
    rateHi     = VECS[0].hi;
    advSel     = VECS[0].code;

    // R1: reset state, then idle until the first frame pulse
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R1", int'(serOut), 0, "serOut in reset");
      check("R1", int'(byteReq), 0, "byteReq in reset");
    end
    rstN    = 1'b1;
    pulseEn = 1'b1;
    while (pn != F - 1) begin
      tick();
      check("R1", int'(serOut), 0, "serOut before pulse");
      check("R1", int'(byteReq), 0, "byteReq before pulse");
    end

    // warm-up frame after alignment
    for (int t = 0; t < F; t++) tick();

    // vector table: one checked frame per entry, next entry set mid-frame
    for (int i = 0; i < NV; i++) begin
      vec_t cur, nxt;
      bit changed;
      int o, lim;
      cur     = VECS[i];
      nxt     = (i + 1 < NV) ? VECS[i + 1] : cur;
      changed = (nxt != cur);
      o       = cur.hi ? int'(cur.code) : 4 * int'(cur.code);
      lim     = changed ? F - o : F;
      for (int t = 0; t < F; t++) begin
        tick();
        if (pn < lim) checkTick(cur, changed);
        if (pn == F / 2) begin
          rateHi = nxt.hi;
          advSel = nxt.code;
        end
      end
    end

    // R1: reset mid-run, then no frame pulse
    @(negedge clk);
    rstN    = 1'b0;
    pulseEn = 1'b0;
    tick();
    check("R1", int'(serOut), 0, "serOut after mid-run reset");
    check("R1", int'(byteReq), 0, "byteReq after mid-run reset");
    rstN = 1'b1;
    for (int t = 0; t < 300; t++) begin
      tick();
      check("R1", int'(byteReq), 0, "byteReq without pulse");
      check("R1", int'(serOut), 0, "serOut without pulse");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule